// File: doc/BRIEF.md
# Parity Error Status Port

This block is a small status register that sits on the I/O side of a memory board. The memory read path checks parity on its own. When it finds a bad byte, it raises a one-cycle capture strobe along with a low-bank flag, a high-bank flag and the two address bits that pick the row of chips. The port keeps the first such record, raises one interrupt line, and holds both until software clears them.

Software reaches the port through I/O read and write commands on a 16-bit address. An address selects the port only when three bits are fixed high. One further bit must equal a configured level. Each of the four lowest bits and each of the upper eight bits is set by configuration to be either required-low or ignored. A selected read returns the record on the four lowest data bits. Any selected write clears the record, whatever the data. The initialize input also clears it. Each selected command gets a transfer acknowledge one clock later.

Top module: `parity_status_port`

## Requirements
- R1: The port is selected only when address bits 4, 5 and 7 are all 1.
- R2: Address bit k (0 to 3) must be 0 for selection when LOW_MASK[k] is 1, and is ignored when LOW_MASK[k] is 0.
- R3: Address bit 6 must equal BIT6_LEVEL for selection.
- R4: Address bit 8+k must be 0 for selection when HIGH_MASK[k] is 1, and is ignored when HIGH_MASK[k] is 0.
- R5: A capture strobe with at least one error flag stores the record as bit 0 = low-bank flag, bit 1 = high-bank flag, bits 3:2 = row select. A strobe with both flags low is ignored.
- R6: Once a record is held (bit 0 or bit 1 set), later capture strobes leave it unchanged until it is cleared.
- R7: A selected I/O read drives the record onto rdData[3:0], drives the upper data bits to 0 and raises rdOe. Without a selected read, rdData is 0 and rdOe is low.
- R8: While a record is held, irq[IRQ_SEL] is 1; every other irq line is always 0.
- R9: A selected I/O write clears the record and the interrupt on the next clock, and this clear wins over a capture in the same cycle. A write to an unselected address changes nothing.
- R10: The initialize input clears the record and the interrupt on the next clock.
- R11: ack is 1 in the cycle after a cycle holding a selected read or write command. It is 0 in the cycle after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initReq | input | 1 | Synchronous initialize, clears the record |
| ioAddr | input | 16 | I/O address |
| ioRd | input | 1 | I/O read command |
| ioWr | input | 1 | I/O write command |
| capStb | input | 1 | Parity check result strobe from the read path |
| lowErr | input | 1 | Low-bank parity error flag |
| highErr | input | 1 | High-bank parity error flag |
| rowSel | input | 2 | Row-select address bits of the failing read |
| rdData | output | 16 | Read data to the bus |
| rdOe | output | 1 | Read data valid for this port |
| ack | output | 1 | Transfer acknowledge |
| irq | output | 8 | Interrupt request lines |

## Verification
The bench builds the port with LOW_MASK = 4'b0101, BIT6_LEVEL = 1, HIGH_MASK = 8'hF0 and IRQ_SEL = 5. With these settings, address bits 1, 3 and 8 to 11 act as don't-care while their neighbours stay required-low. Bit 6 must be high, and the interrupt goes to a middle line rather than an end line. These values let one run show both the required-low and the ignored case in each masked group. The run also shows the fixed-high bits and the level-matched bit rejecting addresses, and confirms that only the chosen irq line ever moves.

// File: rtl/parstat_pkg.sv
package parstat_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // strobe carrying at least one error flag
    logic clear;    // initialize or selected write
    logic readEn;   // selected read
  } statusCtl_t;

  localparam int ROW_W    = 2;
  localparam int STATUS_W = 2 + ROW_W;
endpackage

// File: rtl/parstat_ctrl.sv
module parstat_ctrl
  import parstat_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [3:0]        LOW_MASK   = 4'hF,
  parameter logic              BIT6_LEVEL = 1'b1,
  parameter logic [ADDR_W-9:0] HIGH_MASK  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              capStb,
  input  logic              lowErr,
  input  logic              highErr,
  output statusCtl_t        ctl,
  output logic              ack
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hiBitOk;
  logic [3:0]      loBitOk;
  logic            fixedOk, midOk, portSel, cmdSel, ackQ;

  for (genvar i = 0; i < 4; i++) begin : g_lo
    assign loBitOk[i] = !(LOW_MASK[i] && ioAddr[i]);
  end
  for (genvar i = 0; i < HI_W; i++) begin : g_hi
    assign hiBitOk[i] = !(HIGH_MASK[i] && ioAddr[8+i]);
  end

  assign fixedOk = ioAddr[4] & ioAddr[5] & ioAddr[7];
  assign midOk   = (ioAddr[6] == BIT6_LEVEL);
  assign portSel = fixedOk & midOk & (&loBitOk) & (&hiBitOk);
  assign cmdSel  = (ioRd | ioWr) & portSel;

  always_comb begin
    ctl.capture = capStb & (lowErr | highErr);
    ctl.clear   = initReq | (ioWr & portSel);
    ctl.readEn  = ioRd & portSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackQ <= 1'b0;
    else       ackQ <= cmdSel;
  end
  assign ack = ackQ;

  // R11: no command in a cycle means no acknowledge in the next
  a_r11_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd || ioWr) |=> !ack);
  // R11: an acknowledge only rises behind a command
  a_r11_ack_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> $past(ioRd || ioWr));
endmodule

// File: rtl/parstat_dp.sv
module parstat_dp
  import parstat_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_IRQ  = 8,
  parameter int IRQ_SEL  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  statusCtl_t        ctl,
  input  logic              lowErr,
  input  logic              highErr,
  input  logic [ROW_W-1:0]  rowSel,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe,
  output logic [NUM_IRQ-1:0] irq
);
  logic [STATUS_W-1:0] statusQ;
  logic                held;

  assign held = statusQ[0] | statusQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     statusQ <= '0;
    else if (ctl.clear)            statusQ <= '0;
    else if (ctl.capture && !held) statusQ <= {rowSel, highErr, lowErr};
  end

  assign rdOe   = ctl.readEn;
  assign rdData = ctl.readEn ? DATA_W'(statusQ) : '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    if (i == IRQ_SEL) begin : g_on
      assign irq[i] = held;
    end else begin : g_off
      assign irq[i] = 1'b0;
    end
  end

  // R8: at most one interrupt line active
  a_r8_irq_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irq));
  // R9 R10: a clear leaves no interrupt behind
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (irq == '0));
  // R6: a held record does not move unless cleared
  a_r6_hold_first: assert property (@(posedge clk) disable iff (!rstN)
    (held && !ctl.clear) |=> $stable(statusQ));
  // R5: a flagged strobe raises the interrupt
  a_r5_capture_sets: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.clear) |=> irq[IRQ_SEL]);
endmodule

// File: rtl/parity_status_port.sv
module parity_status_port
  import parstat_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 16,
  parameter int                NUM_IRQ    = 8,
  parameter int                IRQ_SEL    = 7,
  parameter logic [3:0]        LOW_MASK   = 4'hF,
  parameter logic              BIT6_LEVEL = 1'b1,
  parameter logic [ADDR_W-9:0] HIGH_MASK  = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initReq,
  input  logic [ADDR_W-1:0]  ioAddr,
  input  logic               ioRd,
  input  logic               ioWr,
  input  logic               capStb,
  input  logic               lowErr,
  input  logic               highErr,
  input  logic [1:0]         rowSel,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdOe,
  output logic               ack,
  output logic [NUM_IRQ-1:0] irq
);
  statusCtl_t ctl;

  parstat_ctrl #(
    .ADDR_W(ADDR_W), .LOW_MASK(LOW_MASK),
    .BIT6_LEVEL(BIT6_LEVEL), .HIGH_MASK(HIGH_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .initReq(initReq), .ioAddr(ioAddr),
    .ioRd(ioRd), .ioWr(ioWr), .capStb(capStb), .lowErr(lowErr),
    .highErr(highErr), .ctl(ctl), .ack(ack)
  );

  parstat_dp #(
    .DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ), .IRQ_SEL(IRQ_SEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lowErr(lowErr),
    .highErr(highErr), .rowSel(rowSel), .rdData(rdData),
    .rdOe(rdOe), .irq(irq)
  );
endmodule

// File: tb/parity_status_port_tb.sv
`timescale 1ns/1ps
module parity_status_port_tb;
  localparam int         IRQ_SEL    = 5;
  localparam logic [3:0] LOW_MASK   = 4'b0101;
  localparam logic       BIT6_LEVEL = 1'b1;
  localparam logic [7:0] HIGH_MASK  = 8'hF0;

  logic clk = 1'b0, rstN = 1'b0, initReq = 1'b0;
  logic [15:0] ioAddr = '0;
  logic ioRd = 1'b0, ioWr = 1'b0, capStb = 1'b0, lowErr = 1'b0, highErr = 1'b0;
  logic [1:0] rowSel = '0;
  logic [15:0] rdData;
  logic rdOe, ack;
  logic [7:0] irq;

  always #2.5 clk = ~clk;

  parity_status_port #(
    .IRQ_SEL(IRQ_SEL), .LOW_MASK(LOW_MASK),
    .BIT6_LEVEL(BIT6_LEVEL), .HIGH_MASK(HIGH_MASK)
  ) u_dut (
    .clk(clk), .rstN(rstN), .initReq(initReq), .ioAddr(ioAddr),
    .ioRd(ioRd), .ioWr(ioWr), .capStb(capStb), .lowErr(lowErr),
    .highErr(highErr), .rowSel(rowSel), .rdData(rdData),
    .rdOe(rdOe), .ack(ack), .irq(irq)
  );

  typedef struct {
    string       tag;
    logic [15:0] rd;
    logic        oe;
    logic        ack;
    logic [7:0]  irq;
  } expItem_t;

  expItem_t expQ[$];
  int vectors = 0, fails = 0;
  bit done = 1'b0;

  // reference state, from the requirements
  logic [3:0] mStatus = '0;
  logic       mAck = 1'b0;

  function automatic bit refSel(logic [15:0] a);
    bit ok = a[4] && a[5] && a[7] && (a[6] == BIT6_LEVEL);
    for (int k = 0; k < 4; k++) if (LOW_MASK[k] && a[k]) ok = 0;
    for (int k = 0; k < 8; k++) if (HIGH_MASK[k] && a[8+k]) ok = 0;
    return ok;
  endfunction

  task automatic drive(string tag, logic [15:0] a, logic rd, logic wr,
                       logic cap, logic lo, logic hi, logic [1:0] row, logic ini);
    expItem_t e;
    bit sel;
    @(posedge clk); #1;
    ioAddr = a; ioRd = rd; ioWr = wr; capStb = cap;
    lowErr = lo; highErr = hi; rowSel = row; initReq = ini;
    sel = refSel(a);
    e.tag = tag;
    e.oe  = rd && sel;
    e.rd  = (rd && sel) ? {12'b0, mStatus} : 16'h0;
    e.ack = mAck;
    e.irq = (mStatus[1:0] != 0) ? (8'b1 << IRQ_SEL) : 8'h0;
    expQ.push_back(e);
    mAck = (rd || wr) && sel;
    if (ini || (wr && sel)) mStatus = '0;
    else if (cap && (lo || hi) && mStatus[1:0] == 0) mStatus = {row, hi, lo};
  endtask

  task automatic idle(string tag);           drive(tag, 16'h0, 0,0,0,0,0,2'd0,0); endtask
  task automatic rdAt(string tag, logic [15:0] a); drive(tag, a, 1,0,0,0,0,2'd0,0); endtask
  task automatic wrAt(string tag, logic [15:0] a); drive(tag, a, 0,1,0,0,0,2'd0,0); endtask
  task automatic cap(string tag, logic lo, logic hi, logic [1:0] r);
    drive(tag, 16'h0, 0,0,1,lo,hi,r,0);
  endtask

  // monitor: pop expectations and compare between clock edges
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      vectors++;
      if (rdData !== e.rd || rdOe !== e.oe || ack !== e.ack || irq !== e.irq) begin
        fails++;
        $display("FAIL %s: rd=%h oe=%b ack=%b irq=%b expected rd=%h oe=%b ack=%b irq=%b",
                 e.tag, rdData, rdOe, ack, irq, e.rd, e.oe, e.ack, e.irq);
      end
    end
  end

  localparam logic [15:0] PORT = 16'h00F0;

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    idle("R8 R11 reset state");
    rdAt("R7 read empty", PORT);
    idle("R11 ack after read");
    idle("R11 ack drops");
    cap("R5 capture low row2", 1, 0, 2'd2);
    idle("R8 irq raised");
    rdAt("R5 R7 read record", PORT);
    cap("R6 second error", 0, 1, 2'd1);
    rdAt("R6 record kept", PORT);
    rdAt("R2 dont-care bits 1,3", 16'h00FA);
    rdAt("R4 dont-care bits 8-11", 16'h0FF0);
    rdAt("R2 required-low bit 0", 16'h00F1);
    idle("R11 no ack unselected");
    rdAt("R2 required-low bit 2", 16'h00F4);
    rdAt("R4 required-low bit 12", 16'h10F0);
    rdAt("R4 required-low bit 15", 16'h80F0);
    rdAt("R3 bit 6 level", 16'h00B0);
    rdAt("R1 bit 4 low", 16'h00E0);
    rdAt("R1 bit 5 low", 16'h00D0);
    rdAt("R1 bit 7 low", 16'h0070);
    wrAt("R9 unselected write", 16'h00B0);
    rdAt("R9 record survives", PORT);
    wrAt("R9 selected write", 16'h0AFA);
    idle("R9 R11 cleared, ack");
    rdAt("R9 read after clear", PORT);
    cap("R5 strobe without flags", 0, 0, 2'd3);
    rdAt("R5 ignored strobe", PORT);
    cap("R5 capture high row3", 0, 1, 2'd3);
    rdAt("R5 read high row3", PORT);
    drive("R10 initialize", 16'h0, 0,0,0,0,0,2'd0,1);
    rdAt("R10 read after init", PORT);
    cap("R5 capture both row1", 1, 1, 2'd1);
    drive("R9 clear beats capture", PORT, 0,1,1,1,0,2'd2,0);
    rdAt("R9 read after race", PORT);
    idle("R8 irq quiet");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule